// File: doc/BRIEF.md
# Debug Halt Control and Status Unit

This unit sits between an external debugger and a small processor core. It holds three word registers on a simple register bus. The first keeps a flag for each cause of a debug halt. The second holds the debugger's control bits (enable, halt, single step, interrupt mask) next to read-only core status. The third selects which events catch into debug state and whether the watchpoint unit may halt the core. It drives a halt request, a single-step enable and an interrupt-mask line into the core, and it takes back the core's halted acknowledgement.

Debug event pulses (breakpoint, watchpoint match, external debug request) and the core's hard-fault and reset indications are qualified by the enable bits. Any event that is let through records its own cause and also sets the halt control bit without any write from the debugger. The bus accepts a transfer on every cycle that `bus_req` is high and has no back-pressure. Read data is combinational and valid in the same cycle as the request. A read's clear side effect takes place at the clock edge that ends that cycle. Offsets are byte addresses: 0x00 cause flags, 0xC0 control/status, 0xCC catch control.

Top module: `dbg_halt_unit`

## Requirements
- R1: After `rst_n` is released, all three registers read zero and `halt_req`, `step_en`, `irq_mask` and `wpt_enable` are low.
- R2: While debug enable (control bit 0) is 1, a pulse on `ev_bkpt` sets cause bit 1 and a pulse on `ev_ext` sets cause bit 4. Cause bits stay set until 1 is written to them at offset 0x00. A set in the same cycle wins over the clear.
- R3: `ev_wpt` sets cause bit 2 and counts as an event only while catch-control bit 24 (watchpoint unit enable) is 1. Otherwise it has no effect on the flags or on `halt_req`. `wpt_enable` mirrors that bit.
- R4: Every event that is let through (cause bits 1 to 4) sets the halt control bit (bit 1 at 0xC0), so `halt_req` rises on the next cycle.
- R5: While debug enable is 0, `halt_req`, `step_en` and `irq_mask` are low whatever the stored control bits are, and no debug event sets a cause flag.
- R6: Cause bit 0 is set by a write to 0xC0 that carries both enable and halt as 1. It is also set when `core_halted` rises while single step (bit 2) and enable are 1.
- R7: Status bit 24 at 0xC0 is set by `core_retire` and cleared by a read of 0xC0.
- R8: Status bit 25 at 0xC0 is set while `core_rst` is high. A read clears it only if `core_rst` is low in that cycle, so while the core is held in reset, every read returns 1.
- R9: `core_rst` clears the halt control bit, except when catch-control bit 0 (reset catch) and enable are 1. In that case the halt bit is set and cause bit 3 is set.
- R10: A `core_hardfault` pulse with catch-control bit 10 and enable set sets cause bit 3 and the halt bit.
- R11: Unused bits read zero. Writes to them, and to any unmapped offset, are ignored, and unmapped offsets read zero.
- R12: Status bit 16 at 0xC0 follows `core_regrdy` and bit 17 follows `core_halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Transfer request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| ev_bkpt | input | 1 | Breakpoint event pulse |
| ev_wpt | input | 1 | Watchpoint match pulse |
| ev_ext | input | 1 | External debug request pulse |
| core_hardfault | input | 1 | Hard-fault entry pulse |
| core_rst | input | 1 | Core reset level |
| core_retire | input | 1 | Instruction retired pulse |
| core_halted | input | 1 | Core halted acknowledge |
| core_regrdy | input | 1 | Register transfer ready |
| halt_req | output | 1 | Halt request to core |
| step_en | output | 1 | Single-step enable |
| irq_mask | output | 1 | Masks external, tick and pend-service interrupts |
| wpt_enable | output | 1 | Watchpoint unit global enable |

## Verification
The hardest situation to reach is a mix of events in one cycle under every setting of the gates: enable, watchpoint enable and hard-fault catch each change what a given pulse may record. The bench sweeps all 128 combinations of four event inputs and three gate bits. Before each combination it clears the flags and the halt bit through the bus. It then pulses the events together in one cycle and compares the cause register and `halt_req` with values built from the gate arithmetic. Reset held across reads is reached by keeping `core_rst` high over two reads and then releasing it.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam logic [7:0] OFS_CAUSE  = 8'h00;
  localparam logic [7:0] OFS_CTLSTS = 8'hC0;
  localparam logic [7:0] OFS_CATCH  = 8'hCC;

  localparam int NUM_CAUSE = 5;
  localparam int CS_HALT = 0;
  localparam int CS_BKPT = 1;
  localparam int CS_WPT  = 2;
  localparam int CS_VC   = 3;
  localparam int CS_EXT  = 4;

  localparam int CT_EN   = 0;
  localparam int CT_HALT = 1;
  localparam int CT_STEP = 2;
  localparam int CT_MASK = 3;
  localparam int ST_RDY  = 16;
  localparam int ST_HLT  = 17;
  localparam int ST_RET  = 24;
  localparam int ST_RST  = 25;

  localparam int CC_VCRST = 0;
  localparam int CC_VCHF  = 10;
  localparam int CC_WPTEN = 24;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctl_t;
endpackage

// File: rtl/dbgc_cause_flags.sv
module dbgc_cause_flags #(
  parameter int NUM = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_vec,
  input  logic           clr_wr,
  input  logic [NUM-1:0] clr_vec,
  output logic [NUM-1:0] flags
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_vec[i] | (flags[i] & ~(clr_wr & clr_vec[i]));
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !(clr_wr && clr_vec[i]) |=> flags[i]); // R2
  end
endmodule

// File: rtl/dbgc_catch_ctl.sv
module dbgc_catch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wd_vcrst,
  input  logic wd_vchf,
  input  logic wd_wpten,
  output logic vc_rst,
  output logic vc_hf,
  output logic wpt_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_rst <= 1'b0;
      vc_hf  <= 1'b0;
      wpt_en <= 1'b0;
    end else if (wr_en) begin
      vc_rst <= wd_vcrst;
      vc_hf  <= wd_vchf;
      wpt_en <= wd_wpten;
    end
  end

  AST_CATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wpt_en) && $stable(vc_rst) && $stable(vc_hf)); // R11
endmodule

// File: rtl/dbgc_halt_ctl.sv
module dbgc_halt_ctl
  import dbgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ctl_t wd,
  input  logic rd_stb,
  input  logic core_rst,
  input  logic core_retire,
  input  logic core_halted,
  input  logic evt_any,
  input  logic vc_rst,
  output ctl_t ctl,
  output logic retire_st,
  output logic reset_st,
  output logic halted_evt,
  output logic halt_req,
  output logic step_en,
  output logic irq_mask
);
  logic halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      retire_st <= 1'b0;
      reset_st  <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        ctl.en   <= wd.en;
        ctl.step <= wd.step;
        ctl.mask <= wd.mask;
      end
      if (core_rst)     ctl.halt <= vc_rst & ctl.en;
      else if (evt_any) ctl.halt <= 1'b1;
      else if (wr_en)   ctl.halt <= wd.halt;
      retire_st <= core_retire | (retire_st & ~rd_stb);
      reset_st  <= core_rst | (reset_st & ~rd_stb);
      halted_q  <= core_halted;
    end
  end

  assign halted_evt = (wr_en & wd.en & wd.halt) |
                      (core_halted & ~halted_q & ctl.step & ctl.en);
  assign halt_req = ctl.halt & ctl.en;
  assign step_en  = ctl.step & ctl.en;
  assign irq_mask = ctl.mask & ctl.en;

  AST_EVT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any && !core_rst |=> ctl.halt); // R4
  AST_RST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst && !vc_rst |=> !ctl.halt); // R9
  AST_RETIRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_retire |=> retire_st); // R7
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> reset_st); // R8
endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
  import dbgc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_bkpt,
  input  logic              ev_wpt,
  input  logic              ev_ext,
  input  logic              core_hardfault,
  input  logic              core_rst,
  input  logic              core_retire,
  input  logic              core_halted,
  input  logic              core_regrdy,
  output logic              halt_req,
  output logic              step_en,
  output logic              irq_mask,
  output logic              wpt_enable
);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_CTLSTS = ADDR_W'(OFS_CTLSTS);
  localparam logic [ADDR_W-1:0] A_CATCH  = ADDR_W'(OFS_CATCH);

  logic sel_cause, sel_ctl, sel_catch;
  logic wr_cause, wr_ctl, wr_catch, rd_ctl;
  logic [NUM_CAUSE-1:0] set_vec, flags;
  ctl_t ctl, wd_ctl;
  logic retire_st, reset_st, halted_evt, evt_any;
  logic vc_rst, vc_hf;
  logic unused_wdata;

  assign sel_cause = bus_req && (bus_addr == A_CAUSE);
  assign sel_ctl   = bus_req && (bus_addr == A_CTLSTS);
  assign sel_catch = bus_req && (bus_addr == A_CATCH);
  assign wr_cause  = sel_cause & bus_we;
  assign wr_ctl    = sel_ctl & bus_we;
  assign wr_catch  = sel_catch & bus_we;
  assign rd_ctl    = sel_ctl & ~bus_we;
  assign unused_wdata = ^bus_wdata;

  assign wd_ctl.en   = bus_wdata[CT_EN];
  assign wd_ctl.halt = bus_wdata[CT_HALT];
  assign wd_ctl.step = bus_wdata[CT_STEP];
  assign wd_ctl.mask = bus_wdata[CT_MASK];

  always_comb begin
    set_vec          = '0;
    set_vec[CS_HALT] = halted_evt;
    set_vec[CS_BKPT] = ctl.en & ev_bkpt;
    set_vec[CS_WPT]  = ctl.en & ev_wpt & wpt_enable;
    set_vec[CS_VC]   = ctl.en & ((core_rst & vc_rst) | (core_hardfault & vc_hf));
    set_vec[CS_EXT]  = ctl.en & ev_ext;
  end
  assign evt_any = |set_vec[NUM_CAUSE-1:1];

  dbgc_cause_flags #(.NUM(NUM_CAUSE)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_wr  (wr_cause),
    .clr_vec (bus_wdata[NUM_CAUSE-1:0]),
    .flags   (flags)
  );

  dbgc_halt_ctl u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_ctl),
    .wd          (wd_ctl),
    .rd_stb      (rd_ctl),
    .core_rst    (core_rst),
    .core_retire (core_retire),
    .core_halted (core_halted),
    .evt_any     (evt_any),
    .vc_rst      (vc_rst),
    .ctl         (ctl),
    .retire_st   (retire_st),
    .reset_st    (reset_st),
    .halted_evt  (halted_evt),
    .halt_req    (halt_req),
    .step_en     (step_en),
    .irq_mask    (irq_mask)
  );

  dbgc_catch_ctl u_catch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_catch),
    .wd_vcrst (bus_wdata[CC_VCRST]),
    .wd_vchf  (bus_wdata[CC_VCHF]),
    .wd_wpten (bus_wdata[CC_WPTEN]),
    .vc_rst   (vc_rst),
    .vc_hf    (vc_hf),
    .wpt_en   (wpt_enable)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_cause) begin
      bus_rdata[NUM_CAUSE-1:0] = flags;
    end else if (sel_ctl) begin
      bus_rdata[CT_EN]   = ctl.en;
      bus_rdata[CT_HALT] = ctl.halt;
      bus_rdata[CT_STEP] = ctl.step;
      bus_rdata[CT_MASK] = ctl.mask;
      bus_rdata[ST_RDY]  = core_regrdy;
      bus_rdata[ST_HLT]  = core_halted;
      bus_rdata[ST_RET]  = retire_st;
      bus_rdata[ST_RST]  = reset_st;
    end else if (sel_catch) begin
      bus_rdata[CC_VCRST] = vc_rst;
      bus_rdata[CC_VCHF]  = vc_hf;
      bus_rdata[CC_WPTEN] = wpt_enable;
    end
  end

  AST_WPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[CS_WPT]) |-> $past(wpt_enable)); // R3
  AST_OFF_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en && !wr_ctl |=> !$rose(flags[CS_BKPT]) && !$rose(flags[CS_EXT])); // R5
endmodule

// File: tb/tb_dbg_halt_unit.sv
`timescale 1ns/1ps
module tb_dbg_halt_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_bkpt = 0, ev_wpt = 0, ev_ext = 0, core_hardfault = 0;
  logic core_rst = 0, core_retire = 0, core_halted = 0, core_regrdy = 0;
  logic halt_req, step_en, irq_mask, wpt_enable;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dbg_halt_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, d); chk("R1 cause", d, 0);
    rd(8'hC0, d); chk("R1 ctlsts", d, 0);
    rd(8'hCC, d); chk("R1 catch", d, 0);
    chk("R1 outputs", {halt_req, step_en, irq_mask, wpt_enable}, 0);

    // Sweep: bits 0 bkpt,1 wpt,2 ext,3 hardfault,4 wpt unit en,5 hf catch,6 debug en
    for (int i = 0; i < 128; i++) begin
      logic de, we, vh;
      logic [31:0] exp;
      de = i[6]; we = i[4]; vh = i[5];
      wr(8'hCC, (32'(we) << 24) | (32'(vh) << 10));
      wr(8'hC0, 32'(de));
      wr(8'h00, 32'h1F);
      @(negedge clk);
      ev_bkpt = i[0]; ev_wpt = i[1]; ev_ext = i[2]; core_hardfault = i[3];
      @(negedge clk);
      ev_bkpt = 0; ev_wpt = 0; ev_ext = 0; core_hardfault = 0;
      exp = de ? {27'd0, i[2], i[3] & vh, i[1] & we, i[0], 1'b0} : 32'd0;
      rd(8'h00, d);
      chk("R2/R3/R5/R10 sweep cause", d, exp);
      chk("R4/R5 sweep halt_req", 32'(halt_req), 32'(|exp));
      chk("R3 wpt_enable", 32'(wpt_enable), 32'(we));
    end

    // R11 unmapped and unused bits
    wr(8'h00, 32'h1F);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R11 unmapped", d, 0);
    wr(8'hCC, 32'hFFFF_FFFF);
    rd(8'hCC, d); chk("R11 catch bits", d, 32'h0100_0401);
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, d); chk("R11 ctl bits", d, 32'h0000_000F);
    rd(8'h00, d); chk("R6 write halt sets cause0", d, 32'h1);

    // R5 gating by debug enable
    wr(8'hCC, 0);
    wr(8'hC0, 32'h9);
    chk("R5 mask on", 32'(irq_mask), 1);
    wr(8'hC0, 32'hE);
    chk("R5 gated outputs", {halt_req, step_en, irq_mask}, 0);

    // R6 step halt, R12 status follow
    wr(8'hC0, 32'h5);
    wr(8'h00, 32'h1F);
    @(negedge clk); core_halted = 1; core_regrdy = 1;
    @(negedge clk);
    rd(8'h00, d); chk("R6 step halt cause0", d, 32'h1);
    rd(8'hC0, d); chk("R12 status follow", d, 32'h0003_0005);
    core_halted = 0; core_regrdy = 0;

    // R2 set wins over clear in same cycle
    wr(8'h00, 32'h1F);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h1F; ev_bkpt = 1;
    @(negedge clk);
    bus_req = 0; bus_we = 0; ev_bkpt = 0;
    rd(8'h00, d); chk("R2 set beats clear", d, 32'h2);

    // R7 retire sticky
    rd(8'hC0, d);
    @(negedge clk); core_retire = 1;
    @(negedge clk); core_retire = 0;
    rd(8'hC0, d); chk("R7 retire set", d[24], 1);
    rd(8'hC0, d); chk("R7 retire cleared", d[24], 0);

    // R9 core reset clears halt without catch
    wr(8'hC0, 32'h3);
    chk("R9 halt before", 32'(halt_req), 1);
    @(negedge clk); core_rst = 1;
    @(negedge clk);
    chk("R9 halt cleared", 32'(halt_req), 0);
    // R8 held reset
    rd(8'hC0, d); chk("R8 reset held 1st", d[25], 1);
    rd(8'hC0, d); chk("R8 reset held 2nd", d[25], 1);
    core_rst = 0;
    rd(8'hC0, d); chk("R8 reset after release", d[25], 1);
    rd(8'hC0, d); chk("R8 reset cleared", d[25], 0);

    // R9 reset catch
    wr(8'hCC, 32'h1);
    wr(8'hC0, 32'h1);
    wr(8'h00, 32'h1F);
    @(negedge clk); core_rst = 1;
    @(negedge clk); core_rst = 0;
    chk("R9 reset catch halt", 32'(halt_req), 1);
    rd(8'h00, d); chk("R9 reset catch cause", d, 32'h8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule